// File: doc/BRIEF.md
# Sample-Rate Bit Clock Generator with Frame Resynchronisation

This block turns a fast source clock into a serial bit clock. A programmable divide value sets the bit-clock period, and an edge-select input chooses whether the source's rising or falling edges produce the bit-clock transitions. With a divide value of zero the source clock passes straight through, or is inverted when the falling edge is selected.

The block also watches an external frame-sync pin. The pin can be set active high or active low, and the block detects the start of each frame pulse on the source clock's rising edge. When resynchronisation is enabled, that detected edge restarts the divider, so the bit clock takes a fixed phase relative to the frame. In every mode the block produces an internal frame-sync pulse that lasts one whole bit-clock period. Logic clocked on the falling edge of the bit clock can therefore always sample it.

Top module: `srg_clkgen`

## Requirements
- R1: While reset is asserted, the bit clock output and the internal frame-sync output are both low, whatever the divide value.
- R2: With a divide value of 0, the bit clock equals the source clock when edge select is 0, and the inverted source clock when edge select is 1.
- R3: With a divide value D of 1 or more, the bit clock period is D+1 source cycles. It is high for ceil((D+1)/2) cycles and low for the rest, so an odd period has the longer high phase.
- R4: With edge select 1 and D of 1 or more, the bit clock follows the same pattern as with edge select 0, but each transition falls on the source falling edge that comes half a source period later.
- R5: With resync enabled, take an active frame-sync edge sampled at source rising edge E. For D of 1 or more, the bit clock (edge select 0) is low after edge E+1 and rises at edge E+2. It then continues with phase 0 of its period.
- R6: The internal frame-sync output goes high at the bit-clock rising edge that follows a detected frame-sync edge. It stays high for exactly D+1 source cycles.
- R7: Only the inactive-to-active transition of the frame-sync pin counts. A pin held active causes no further resync and no further internal frame-sync pulse.
- R8: With resync disabled, a frame-sync edge leaves the bit-clock phase unchanged. The internal frame-sync pulse still appears, starting at the next natural bit-clock rising edge.
- R9: Frame-sync polarity 0 means the pin is active high; polarity 1 means the pin is active low, so a high-to-low transition is the frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fs_pin_i | input | 1 | External frame-sync pin |
| div_i | input | DIV_W | Divide value D; period is D+1 source cycles |
| edge_sel_i | input | 1 | 0: rising source edges make the bit clock, 1: falling edges |
| sync_en_i | input | 1 | 1: a frame-sync edge restarts the divider |
| fs_pol_i | input | 1 | 0: frame-sync pin active high, 1: active low |
| bclk_o | output | 1 | Derived bit clock |
| fs_int_o | output | 1 | Internal frame-sync, one bit-clock period wide |

## Verification
The pin is driven between edges, so the first source rising edge after that samples it. The bit clock is low after the next edge and rises one edge after that. The internal frame-sync output goes high on that same rising edge and stays high for D+1 edges. The bench counts these edges from the drive point and samples each result 1 ns after an edge, where the rising-edge version and the pass-through high level are visible. It samples again 3 ns after the edge, where the falling-edge version and the pass-through low level have settled. In the test with resync disabled, the pin edge is timed so that a wrongly applied resync would shift the bit clock one edge early. The frame pulse is then expected at the next natural wrap of the period.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int DIV_W_DEF = 8;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;
endpackage

// File: rtl/srg_rst_sync.sv
module srg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/srg_fs_detect.sv
module srg_fs_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol_i,
  output logic edge_o
);
  logic smp_q, smp_d;
  logic old_q, old_d;

  always_comb begin
    smp_d = pin_i ^ pol_i;
    old_d = smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      old_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
      old_q <= old_d;
    end
  end

  assign edge_o = smp_q & ~old_q;

  // An edge pulse lasts one cycle, so a held level cannot repeat it
  assert_single_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/srg_divider.sv
module srg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             resync_i,
  output logic             bclk_o,
  output logic             wrap_o
);
  localparam int HW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             bclk_q, bclk_d;
  logic [HW-1:0]    hi_len;
  logic             at_end;

  always_comb begin
    hi_len = ({1'b0, div_i} + HW'(2)) >> 1;
    at_end = (cnt_q >= div_i);
    wrap_o = at_end & ~resync_i;
    if (resync_i)    cnt_d = div_i;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
    bclk_d = ({1'b0, cnt_d} < hi_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk_o = bclk_q;

  // Without resync the count only advances by one or restarts at zero
  assert_free_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !resync_i |=> (cnt_q == '0 || cnt_q == $past(cnt_q) + DIV_W'(1)));
endmodule

// File: rtl/srg_fs_stretch.sv
module srg_fs_stretch (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic edge_i,
  output logic fso_o
);
  logic pend_q, pend_d;
  logic fso_q, fso_d;

  always_comb begin
    pend_d = pend_q;
    fso_d  = fso_q;
    if (wrap_i) begin
      fso_d  = pend_q | edge_i;
      pend_d = 1'b0;
    end else if (edge_i) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      fso_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      fso_q  <= fso_d;
    end
  end

  assign fso_o = fso_q;
endmodule

// File: rtl/srg_clkgen.sv
module srg_clkgen #(
  parameter int DIV_W = srg_pkg::DIV_W_DEF
) (
  input  logic             src_clk,
  input  logic             rst_n,
  input  logic             fs_pin_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             edge_sel_i,
  input  logic             sync_en_i,
  input  logic             fs_pol_i,
  output logic             bclk_o,
  output logic             fs_int_o
);
  import srg_pkg::*;

  logic  rst_sn;
  logic  fs_edge;
  logic  resync;
  logic  bclk_pos;
  logic  bclk_neg;
  logic  wrap;
  logic  pass_mode;
  edge_e edge_sel;

  srg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (src_clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  srg_fs_detect u_det (
    .clk    (src_clk),
    .rst_n  (rst_sn),
    .pin_i  (fs_pin_i),
    .pol_i  (fs_pol_i),
    .edge_o (fs_edge)
  );

  assign resync = fs_edge & sync_en_i;

  srg_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (src_clk),
    .rst_n    (rst_sn),
    .div_i    (div_i),
    .resync_i (resync),
    .bclk_o   (bclk_pos),
    .wrap_o   (wrap)
  );

  srg_fs_stretch u_fs (
    .clk    (src_clk),
    .rst_n  (rst_sn),
    .wrap_i (wrap),
    .edge_i (fs_edge),
    .fso_o  (fs_int_o)
  );

  // Half-period retime for falling-edge operation
  always_ff @(negedge src_clk or negedge rst_sn) begin
    if (!rst_sn) bclk_neg <= 1'b0;
    else         bclk_neg <= bclk_pos;
  end

  always_comb begin
    edge_sel  = edge_e'(edge_sel_i);
    pass_mode = (div_i == '0);
    if (!rst_sn)                bclk_o = 1'b0;
    else if (pass_mode)         bclk_o = src_clk ^ edge_sel_i;
    else if (edge_sel == EDGE_FALL) bclk_o = bclk_neg;
    else                        bclk_o = bclk_pos;
  end

  // Resync places the bit-clock rise two source edges after detection
  assert_resync_rise_R5: assert property (@(posedge src_clk) disable iff (!rst_sn)
    (resync && div_i != '0) ##1 $stable(div_i) |=> $rose(bclk_pos));

  // The frame pulse starts together with a bit-clock rise
  assert_fs_align_R6: assert property (@(posedge src_clk) disable iff (!rst_sn)
    ($rose(fs_int_o) && div_i != '0 && $stable(div_i)) |-> $rose(bclk_pos));

  // The frame pulse ends only at a bit-clock rise, i.e. after a full period
  assert_fs_hold_R6: assert property (@(posedge src_clk) disable iff (!rst_sn)
    ($fell(fs_int_o) && div_i != '0 && $stable(div_i)) |-> $rose(bclk_pos));
endmodule

// File: tb/srg_clkgen_test.sv
`timescale 1ns/1ps
module srg_clkgen_test;
  localparam int DIV_W = 8;
  localparam int NVEC  = 7;
  // entry: {divide value, edge select, frame-sync polarity}
  localparam logic [DIV_W+1:0] VEC [NVEC] = '{
    {8'd1, 1'b0, 1'b0},
    {8'd2, 1'b0, 1'b0},
    {8'd3, 1'b1, 1'b0},
    {8'd4, 1'b0, 1'b1},
    {8'd0, 1'b0, 1'b0},
    {8'd0, 1'b1, 1'b1},
    {8'd5, 1'b1, 1'b1}
  };

  logic             src_clk;
  logic             rst_n;
  logic             fs_pin;
  logic [DIV_W-1:0] div;
  logic             edge_sel;
  logic             sync_en;
  logic             fs_pol;
  logic             bclk;
  logic             fs_int;

  int n_checks;
  int n_fail;
  logic s1, s3, f1;

  srg_clkgen #(.DIV_W(DIV_W)) uut (
    .src_clk    (src_clk),
    .rst_n      (rst_n),
    .fs_pin_i   (fs_pin),
    .div_i      (div),
    .edge_sel_i (edge_sel),
    .sync_en_i  (sync_en),
    .fs_pol_i   (fs_pol),
    .bclk_o     (bclk),
    .fs_int_o   (fs_int)
  );

  initial src_clk = 1'b0;
  always #2 src_clk = ~src_clk;

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one source cycle: sample 1 ns and 3 ns after the rising edge
  task automatic tick();
    @(posedge src_clk);
    #1;
    s1 = bclk;
    f1 = fs_int;
    #2;
    s3 = bclk;
  endtask

  task automatic start(input int d, input logic sel, input logic pol, input logic sen);
    div      = DIV_W'(d);
    edge_sel = sel;
    fs_pol   = pol;
    sync_en  = sen;
    fs_pin   = pol;
    rst_n    = 1'b0;
    tick();
    tick();
    chk(s1 == 1'b0 && s3 == 1'b0, "R1", "bit clock in reset", int'(s1 | s3), 0);
    chk(f1 == 1'b0, "R1", "frame sync in reset", int'(f1), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) tick();
  endtask

  task automatic run_vec(input int d, input logic sel, input logic pol);
    int p, hi, ph, pph;
    logic pos, prev, e1, e3, fe;
    start(d, sel, pol, 1'b1);
    p  = d + 1;
    hi = (d + 2) / 2;
    fs_pin = ~pol;       // R9: active level is the inverse of polarity
    tick();              // E0 samples the pin
    tick();              // E1
    for (int k = 0; k < 2 * p; k++) begin
      tick();            // E2 + k
      ph   = k % p;
      pph  = (k + p - 1) % p;
      pos  = (ph < hi);
      prev = (k == 0) ? 1'b0 : (pph < hi);
      if (d == 0) begin
        e1 = ~sel;
        e3 = sel;
      end else begin
        e1 = sel ? prev : pos;
        e3 = pos;
      end
      fe = (k < p);
      if (d == 0) begin
        chk(s1 == e1 && s3 == e3, "R2", "pass-through level", int'({s1, s3}), int'({e1, e3}));
      end else if (sel) begin
        chk(s1 == e1 && s3 == e3, "R4", "falling-edge bit clock", int'({s1, s3}), int'({e1, e3}));
      end else begin
        chk(s1 == e1 && s3 == e3, "R3", "bit clock pattern after R5 resync",
            int'({s1, s3}), int'({e1, e3}));
      end
      if (k < p)
        chk(f1 == fe, pol ? "R9" : "R6", "frame sync width", int'(f1), int'(fe));
      else
        chk(f1 == fe, "R7", "held level gives no new pulse", int'(f1), int'(fe));
    end
    fs_pin = pol;
    tick();
    tick();
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    fs_pin   = 1'b0;
    div      = '0;
    edge_sel = 1'b0;
    sync_en  = 1'b0;
    fs_pol   = 1'b0;

    for (int v = 0; v < NVEC; v++)
      run_vec(int'(VEC[v][DIV_W+1:2]), VEC[v][1], VEC[v][0]);

    // R8: resync disabled, phase must stay, frame pulse at natural wrap
    start(3, 1'b0, 1'b0, 1'b1);
    fs_pin = 1'b1;
    tick();
    tick();
    for (int t = 0; t < 24; t++) begin
      logic eb, ef;
      tick();            // edge t, phase 0 at t = 0
      eb = ((t % 4) < 2);
      ef = (t < 4) || (t >= 12 && t < 16);
      chk(s1 == eb, "R8", "phase kept with resync off", int'(s1), int'(eb));
      chk(f1 == ef, "R8", "frame pulse at natural wrap", int'(f1), int'(ef));
      if (t == 4) begin
        sync_en = 1'b0;
        fs_pin  = 1'b0;
      end
      if (t == 8) fs_pin = 1'b1;   // sampled at t=9, detected for t=10
    end
    fs_pin = 1'b0;

    // R1: reset applied in the middle of operation
    rst_n = 1'b0;
    #1;
    chk(bclk == 1'b0 && fs_int == 1'b0, "R1", "asynchronous reset clears outputs",
        int'({bclk, fs_int}), 0);
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule